// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out the atomic memory instructions of a 64-bit virtual machine. The execution stage hands it one atomic instruction: the opcode byte, the signed 16-bit offset, the 32-bit immediate that names the operation, and the current values of the destination-address register, the source register and register zero. The unit then runs a locked read-modify-write on a single-port memory. That memory has a read strobe, a write strobe, an address, data in each direction and a ready handshake. When it finishes, the unit reports which register write-backs the pipeline must perform and with what value.

The supported operations are add, or, and, xor, exchange and compare-exchange, each on a 32-bit or 64-bit word. The simple operations may carry a fetch flag, which returns the old memory value to the source register. Exchange always returns the old value to the source register. Compare-exchange uses register zero both as the value to compare against and as the destination of the old value.

The control is a five-state machine. IDLE waits for `start`. IDLE→READ is taken on a valid start. IDLE→DONE is taken on a start that does not decode. READ holds the read strobe until `mem_ready`, then goes READ→MODIFY. MODIFY computes the new value, then goes MODIFY→WRITE, or MODIFY→DONE when a compare-exchange does not match. WRITE holds the write strobe until `mem_ready`, then goes WRITE→DONE. DONE lasts one cycle, then goes DONE→IDLE. `lock` is high in READ, MODIFY and WRITE, so that other masters are held off.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is accepted only when the opcode is 0xC3 (32-bit) or 0xDB (64-bit). These are the store-register class (bits 2:0 = 3), atomic mode (bits 7:5 = 6) and size field (bits 4:3) 0 or 3. The immediate must be one of 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xA0, 0xA1, 0xE1 or 0xF1. Anything else gives `done` with `err`=1, no write-back, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: The memory address is the destination-address value plus the offset sign-extended to 64 bits.
- R3: Immediates 0x00/0x40/0x50/0xA0 (and the same values with bit 0 set) write old+src, old|src, old&src and old^src respectively.
- R4: When immediate bit 0 is set on a simple operation, `src_wb_en` is 1 during `done` and `src_wb_data` holds the old memory value. When bit 0 is clear, `src_wb_en` stays 0.
- R5: Exchange (0xE1) writes the source value to memory and returns the old value on `src_wb_data` with `src_wb_en`=1.
- R6: Compare-exchange (0xF1) with old value equal to register zero writes the source value. In every case it sets `r0_wb_en`=1 with the old value on `r0_wb_data` and leaves `src_wb_en`=0.
- R7: Compare-exchange with unequal values performs no write (`mem_wr` never rises).
- R8: 32-bit operations use only the low 32 bits of each operand, compare only low 32 bits, drive `mem_wide`=0, write data with the upper 32 bits zero, and return the old value zero-extended.
- R9: The sequence is IDLE→READ→MODIFY→WRITE→DONE. With a memory that is always ready, `done` appears in the fourth cycle after the `start` edge. A strobe is held with a stable address until `mem_ready`. `lock` is high whenever a strobe is. `done` lasts one cycle.
- R10: `start` is ignored while the unit is busy, and the operation in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an atomic instruction (sampled in IDLE) |
| opcode | input | 8 | Instruction opcode byte |
| offset | input | 16 | Signed address offset |
| imm | input | 32 | Operation selector immediate |
| dst_val | input | 64 | Base address register value |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register zero value (comparand) |
| mem_addr | output | 64 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data |
| mem_ready | input | 1 | Memory completes the current strobe |
| lock | output | 1 | Memory lock held during the sequence |
| busy | output | 1 | Unit not in IDLE |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Instruction rejected (valid with done) |
| src_wb_en | output | 1 | Write old value to source register |
| src_wb_data | output | 64 | Value for source register |
| r0_wb_en | output | 1 | Write old value to register zero |
| r0_wb_data | output | 64 | Value for register zero |

## Verification
The bench targets 32-bit additions and xors whose operands carry junk in the upper half. A unit that did not mask would leak those bits into memory or into the returned value. Compare-exchange is run with operands that differ only in the upper half under a 32-bit size, which a full-width compare would wrongly reject. It is also run with a true mismatch, where a unit that ignored the skip would still write. Negative offsets test sign extension of the address. Exchange without the fetch bit, a half-word size and a non-atomic mode must all be rejected with no memory strobe. A stalled memory with a second `start` pulse mid-flight exposes a unit that drops the lock or restarts.

// File: rtl/amo_pkg.sv
package amo_pkg;
    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_XCHG,
        OP_CMPX
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    localparam logic [2:0] CLASS_STX   = 3'd3;
    localparam logic [2:0] MODE_ATOMIC = 3'd6;
    localparam logic [1:0] SIZE_WORD   = 2'd0;
    localparam logic [1:0] SIZE_DWORD  = 2'd3;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMMW = 32
) (
    input  logic [7:0]      opcode,
    input  logic [IMMW-1:0] imm,
    output amo_op_e         op,
    output logic            wide,
    output logic            fetch,
    output logic            bad
);
    logic enc_ok;
    logic imm_ok;
    logic hi_zero;

    assign hi_zero = (imm[IMMW-1:8] == '0);
    assign enc_ok  = (opcode[2:0] == CLASS_STX) && (opcode[7:5] == MODE_ATOMIC) &&
                     ((opcode[4:3] == SIZE_WORD) || (opcode[4:3] == SIZE_DWORD));
    assign wide    = (opcode[4:3] == SIZE_DWORD);

    always_comb begin
        op     = OP_ADD;
        fetch  = 1'b0;
        imm_ok = hi_zero;
        unique case (imm[7:0])
            8'h00, 8'h01: begin op = OP_ADD;  fetch = imm[0]; end
            8'h40, 8'h41: begin op = OP_OR;   fetch = imm[0]; end
            8'h50, 8'h51: begin op = OP_AND;  fetch = imm[0]; end
            8'ha0, 8'ha1: begin op = OP_XOR;  fetch = imm[0]; end
            8'he1:        begin op = OP_XCHG; fetch = 1'b1;   end
            8'hf1:        begin op = OP_CMPX; fetch = 1'b0;   end
            default:      imm_ok = 1'b0;
        endcase
    end

    assign bad = !(enc_ok && imm_ok);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_op_e         op,
    input  logic            wide,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] cmp_val,
    output logic [XLEN-1:0] new_val,
    output logic            match
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] src_m;
    logic [XLEN-1:0] cmp_m;
    logic [XLEN-1:0] raw;

    assign src_m = wide ? src_val : {{HALF{1'b0}}, src_val[HALF-1:0]};
    assign cmp_m = wide ? cmp_val : {{HALF{1'b0}}, cmp_val[HALF-1:0]};

    always_comb begin
        unique case (op)
            OP_ADD:  raw = old_val + src_m;
            OP_OR:   raw = old_val | src_m;
            OP_AND:  raw = old_val & src_m;
            OP_XOR:  raw = old_val ^ src_m;
            default: raw = src_m;
        endcase
    end

    assign new_val = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    assign match   = (old_val == cmp_m);
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OFFW = 16,
    parameter int IMMW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [OFFW-1:0] offset,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] r0_val,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_wide,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            lock,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            src_wb_en,
    output logic [XLEN-1:0] src_wb_data,
    output logic            r0_wb_en,
    output logic [XLEN-1:0] r0_wb_data
);
    localparam int HALF = XLEN / 2;

    amo_state_e      state_q, state_d;
    amo_op_e         op_q;
    logic            wide_q, fetch_q, err_q;
    logic [XLEN-1:0] addr_q, src_q, r0_q, old_q, new_q;

    amo_op_e         dec_op;
    logic            dec_wide, dec_fetch, dec_bad;
    logic [XLEN-1:0] alu_new;
    logic            alu_match;

    amo_decode #(.IMMW(IMMW)) u_dec (
        .opcode (opcode),
        .imm    (imm),
        .op     (dec_op),
        .wide   (dec_wide),
        .fetch  (dec_fetch),
        .bad    (dec_bad)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .wide    (wide_q),
        .old_val (old_q),
        .src_val (src_q),
        .cmp_val (r0_q),
        .new_val (alu_new),
        .match   (alu_match)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = dec_bad ? ST_DONE : ST_READ;
            ST_READ:   if (mem_ready) state_d = ST_MODIFY;
            ST_MODIFY: state_d = (op_q == OP_CMPX && !alu_match) ? ST_DONE : ST_WRITE;
            ST_WRITE:  if (mem_ready) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ADD;
            wide_q  <= 1'b0;
            fetch_q <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            src_q   <= '0;
            r0_q    <= '0;
            old_q   <= '0;
            new_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q    <= dec_op;
                wide_q  <= dec_wide;
                fetch_q <= dec_fetch;
                err_q   <= dec_bad;
                addr_q  <= dst_val + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
                src_q   <= src_val;
                r0_q    <= r0_val;
            end
            if (state_q == ST_READ && mem_ready) begin
                old_q <= wide_q ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
            end
            if (state_q == ST_MODIFY) begin
                new_q <= alu_new;
            end
        end
    end

    always_comb begin
        mem_addr    = addr_q;
        mem_wide    = wide_q;
        mem_wdata   = new_q;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        lock        = 1'b0;
        done        = 1'b0;
        err         = 1'b0;
        src_wb_en   = 1'b0;
        r0_wb_en    = 1'b0;
        src_wb_data = old_q;
        r0_wb_data  = old_q;
        busy        = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   ;
            ST_READ:   begin lock = 1'b1; mem_rd = 1'b1; end
            ST_MODIFY: lock = 1'b1;
            ST_WRITE:  begin lock = 1'b1; mem_wr = 1'b1; end
            ST_DONE: begin
                done      = 1'b1;
                err       = err_q;
                src_wb_en = !err_q && fetch_q;
                r0_wb_en  = !err_q && (op_q == OP_CMPX);
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            mem_wide,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            lock,
    input logic            done,
    input logic            err,
    input logic            src_wb_en,
    input logic            r0_wb_en
);
    localparam int HALF = XLEN / 2;

    a_r9_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> lock);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_wide) |-> (mem_wdata[XLEN-1:HALF] == '0));

    a_r1_reject_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !$past(lock));

    a_r4_wb_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en || r0_wb_en) |-> (done && !err));

    a_r6_wb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_wb_en && r0_wb_en));
endmodule

bind amo_rmw_unit amo_rmw_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wide  (mem_wide),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .lock      (lock),
    .done      (done),
    .err       (err),
    .src_wb_en (src_wb_en),
    .r0_wb_en  (r0_wb_en)
);

// File: tb/sim_amo_rmw_unit.sv
`timescale 1ns/1ps
module sim_amo_rmw_unit;
    typedef struct packed {
        logic [7:0]  opc;
        logic [31:0] imm;
        logic [63:0] dst;
        logic [15:0] off;
        logic [63:0] src;
        logic [63:0] r0;
        logic [63:0] mem0;
        logic [63:0] addr;
        logic [63:0] mem1;
        logic        wr;
        logic        s_en;
        logic [63:0] s_v;
        logic        r_en;
        logic [63:0] r_v;
        logic        er;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R3 64-bit add, no fetch, carry across halves
        '{8'hdb, 32'h00, 64'h1000, 16'h0008, 64'h1, 64'h0, 64'h0000_0001_ffff_ffff, 64'h1008, 64'h0000_0002_0000_0000, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R2 R4 add fetch, negative offset
        '{8'hdb, 32'h01, 64'h2000, 16'hfff8, 64'h7, 64'h0, 64'h5, 64'h1ff8, 64'hc, 1'b1, 1'b1, 64'h5, 1'b0, 64'h0, 1'b0},
        // R8 32-bit add fetch, upper junk
        '{8'hc3, 32'h01, 64'h100, 16'h0000, 64'h1234_5678_0000_0002, 64'h0, 64'haaaa_aaaa_ffff_ffff, 64'h100, 64'h1, 1'b1, 1'b1, 64'hffff_ffff, 1'b0, 64'h0, 1'b0},
        // R3 or fetch
        '{8'hdb, 32'h41, 64'h40, 16'h0010, 64'h0f00, 64'h0, 64'hf0, 64'h50, 64'hff0, 1'b1, 1'b1, 64'hf0, 1'b0, 64'h0, 1'b0},
        // R3 and
        '{8'hdb, 32'h50, 64'h80, 16'h0000, 64'h0ff0_0ff0_0ff0_0ff0, 64'h0, 64'hff00_ff00_ff00_ff00, 64'h80, 64'h0f00_0f00_0f00_0f00, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
        // R8 32-bit xor fetch
        '{8'hc3, 32'ha1, 64'h200, 16'h0004, 64'hffff_ffff_ffff_ffff, 64'h0, 64'h1111_1111_8000_0001, 64'h204, 64'h7fff_fffe, 1'b1, 1'b1, 64'h8000_0001, 1'b0, 64'h0, 1'b0},
        // R5 exchange
        '{8'hdb, 32'he1, 64'h300, 16'h0000, 64'h0123_4567_89ab_cdef, 64'h0, 64'hdead_beef_0000_0001, 64'h300, 64'h0123_4567_89ab_cdef, 1'b1, 1'b1, 64'hdead_beef_0000_0001, 1'b0, 64'h0, 1'b0},
        // R6 compare-exchange match
        '{8'hdb, 32'hf1, 64'h400, 16'h0000, 64'h99, 64'h42, 64'h42, 64'h400, 64'h99, 1'b1, 1'b0, 64'h0, 1'b1, 64'h42, 1'b0},
        // R7 compare-exchange mismatch
        '{8'hdb, 32'hf1, 64'h400, 16'h0000, 64'h99, 64'h43, 64'h42, 64'h400, 64'h42, 1'b0, 1'b0, 64'h0, 1'b1, 64'h42, 1'b0},
        // R8 32-bit compare-exchange, upper halves differ
        '{8'hc3, 32'hf1, 64'h500, 16'h0000, 64'h5555_5555_0000_0020, 64'hffff_ffff_0000_0010, 64'h7777_7777_0000_0010, 64'h500, 64'h20, 1'b1, 1'b0, 64'h0, 1'b1, 64'h10, 1'b0},
        // R1 bad immediate
        '{8'hdb, 32'h02, 64'h600, 16'h0000, 64'h1, 64'h0, 64'h33, 64'h0, 64'h33, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
        // R1 half-word size
        '{8'hcb, 32'h00, 64'h600, 16'h0000, 64'h1, 64'h0, 64'h33, 64'h0, 64'h33, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
        // R1 plain store mode
        '{8'h7b, 32'h00, 64'h600, 16'h0000, 64'h1, 64'h0, 64'h33, 64'h0, 64'h33, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
        // R1 exchange without fetch bit
        '{8'hdb, 32'he0, 64'h600, 16'h0000, 64'h1, 64'h0, 64'h33, 64'h0, 64'h33, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0, src_val = '0, r0_val = '0;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_wide, mem_ready;
    logic        lock, busy, done, err, src_wb_en, r0_wb_en;
    logic [63:0] src_wb_data, r0_wb_data;

    logic [63:0] memword = '0;
    logic [63:0] seen_addr = '0;
    logic        rd_seen = 1'b0, wr_seen = 1'b0, wide_seen = 1'b0;
    int          stall = 0;
    int          wcnt = 0;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = memword;
    assign mem_ready = (wcnt >= stall);

    always @(posedge clk) begin
        if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_rd) begin
            rd_seen   <= 1'b1;
            seen_addr <= mem_addr;
            wide_seen <= mem_wide;
        end
        if (mem_wr) wr_seen <= 1'b1;
        if (mem_wr && mem_ready) memword <= mem_wdata;
    end

    amo_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .offset(offset),
        .imm(imm), .dst_val(dst_val), .src_val(src_val), .r0_val(r0_val),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .lock(lock), .busy(busy), .done(done), .err(err),
        .src_wb_en(src_wb_en), .src_wb_data(src_wb_data),
        .r0_wb_en(r0_wb_en), .r0_wb_data(r0_wb_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        opcode = v.opc; imm = v.imm; dst_val = v.dst; offset = v.off;
        src_val = v.src; r0_val = v.r0;
        memword = v.mem0;
        rd_seen = 1'b0; wr_seen = 1'b0; wide_seen = 1'b0; seen_addr = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_vec(input int i, input vec_t v);
        chk($sformatf("R9 v%0d done", i), {63'b0, done}, 64'd1);
        chk($sformatf("R1 v%0d err", i), {63'b0, err}, {63'b0, v.er});
        chk($sformatf("R3 v%0d mem", i), memword, v.mem1);
        chk($sformatf("R7 v%0d write strobe", i), {63'b0, wr_seen}, {63'b0, v.wr});
        chk($sformatf("R4 v%0d src_en", i), {63'b0, src_wb_en}, {63'b0, v.s_en});
        if (v.s_en) chk($sformatf("R5 v%0d src_data", i), src_wb_data, v.s_v);
        chk($sformatf("R6 v%0d r0_en", i), {63'b0, r0_wb_en}, {63'b0, v.r_en});
        if (v.r_en) chk($sformatf("R6 v%0d r0_data", i), r0_wb_data, v.r_v);
        if (v.er) begin
            chk($sformatf("R1 v%0d no read", i), {63'b0, rd_seen}, 64'd0);
        end else begin
            chk($sformatf("R2 v%0d addr", i), seen_addr, v.addr);
            chk($sformatf("R8 v%0d width", i), {63'b0, wide_seen}, {63'b0, (v.opc == 8'hdb)});
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int cyc;
        repeat (3) @(negedge clk);
        chk("R9 reset done", {63'b0, done}, 64'd0);
        chk("R9 reset lock", {63'b0, lock}, 64'd0);
        chk("R9 reset busy", {63'b0, busy}, 64'd0);
        chk("R9 reset strobes", {62'b0, mem_rd, mem_wr}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            launch(VEC[i]);
            wait_done(cyc);
            check_vec(i, VEC[i]);
            if (i == 0) chk("R9 full latency", 64'(cyc), 64'd4);
            if (i == 8) chk("R7 mismatch latency", 64'(cyc), 64'd3);
            if (i == 10) chk("R1 reject latency", 64'(cyc), 64'd1);
            @(negedge clk);
            chk($sformatf("R9 v%0d done one cycle", i), {63'b0, done}, 64'd0);
        end

        // R9 R10: stalled memory, second start while busy
        stall = 3;
        launch(VEC[6]);
        chk("R9 lock during stall", {63'b0, lock}, 64'd1);
        chk("R9 read held", {63'b0, mem_rd}, 64'd1);
        opcode = 8'hdb; imm = 32'h00; src_val = 64'h1; dst_val = 64'h900;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        chk("R10 in-flight exchange mem", memword, VEC[6].mem1);
        chk("R10 in-flight exchange src", src_wb_data, VEC[6].s_v);
        chk("R10 address unchanged", seen_addr, VEC[6].addr);
        repeat (3) @(negedge clk);
        chk("R10 no restart", {63'b0, busy}, 64'd0);
        chk("R10 mem kept", memword, VEC[6].mem1);
        stall = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule